// File: doc/BRIEF.md
# Content-ID Frame Encoder

This block turns a small table of content-identification packets into one framed, protected serial bit stream ready for a spreading stage. A host fills the table through a plain write port, one 77-bit payload word per entry. The block then reads the entries in address order, over and over. Each payload gets an 8-bit CRC, and the resulting 85 information bits are extended by 42 parity bits of a six-error-correcting binary BCH code of length 127.

Every frame opens with a fixed unique word that is sent without scrambling. That word is followed by one 127-bit codeword per table entry. All codeword bits are whitened by a nine-stage scrambler, and the complete frame is then differentially encoded. The output is one bit per accepted beat on a valid/ready handshake, and a start flag marks the first bit of each frame. When the consumer holds ready low, the whole chain waits, so no bit is dropped or repeated.

Top module: `cidenc_top`

## Requirements
- R1: While `rst` is high, `out_valid` and `out_sof` are low at every clock edge.
- R2: A frame is `UW_LEN + 127*N_PKT` accepted bits long, and frames follow back to back. `out_sof` is high on the first bit of each frame and only there.
- R3: The first `UW_LEN` bits of a frame carry `UW_PAT` MSB first, without scrambling. This holds after differential decoding.
- R4: Each 127-bit codeword starts with the 77-bit table word, sent MSB first. The next 8 bits are its CRC. Codewords appear in table address order 0 to `N_PKT-1`.
- R5: The CRC uses the polynomial x^8+x^2+x+1 (0x07) with an all-zero preset. Payload bits are fed MSB first, and the 8 CRC bits are sent MSB first.
- R6: The 42 parity bits complete a codeword c(x) whose first sent bit is the x^126 coefficient. c(x) vanishes at alpha^1, alpha^3, alpha^5, alpha^7, alpha^9 and alpha^11, where alpha is a root of x^7+x^3+1.
- R7: Codeword bits are XORed with a PRBS from a 9-bit register s that is set to all ones at the start of every frame. Each PRBS bit is p = s[8]^s[4], after which s becomes {s[7:0], p}. Unique-word bits do not advance s.
- R8: Each sent bit is the XOR of the pre-coded bit and the previously sent bit. The previous bit counts as 0 for the first bit of each frame.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_bit` and `out_sof` hold their values.
- R10: A write stores `wr_data` at entry `wr_addr`. A packet whose codeword starts after the write carries the new word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | AW = clog2(N_PKT) | Table entry to write |
| wr_data | input | 77 | Payload word to store |
| out_ready | input | 1 | Consumer accepts the current bit |
| out_valid | output | 1 | Output bit is valid |
| out_bit | output | 1 | Encoded serial bit |
| out_sof | output | 1 | First bit of a frame |

## Verification
The checker assumes only that reset is held for at least one clock edge. Beyond that, a beat counts as transferred whenever `out_valid` and `out_ready` are both high, and `out_ready` may do anything. Under these conditions the checker tracks frame position, start-flag placement, unique-word content and stall hold. The bench keeps reset high across several edges and loads the table while reset is asserted. It drives `out_ready` from an irregular repeating mask, so stalls land at many different frame positions. It rewrites one entry during a unique word, when no codeword of that entry is in flight.

// File: rtl/cidenc_pkg.sv
package cidenc_pkg;

    localparam int PAY_W  = 77;
    localparam int CRC_W  = 8;
    localparam int INFO_W = PAY_W + CRC_W;
    localparam int CW_N   = 127;
    localparam int PAR_W  = CW_N - INFO_W;
    localparam int SCR_W  = 9;

    localparam logic [CRC_W-1:0] CRC_POLY = 8'h07;
    localparam logic [6:0]       GF_RED   = 7'h09;   // x^7 = x^3 + 1

    typedef enum logic [1:0] {
        PH_UW,
        PH_DATA,
        PH_CRC,
        PH_PAR
    } phase_e;

    // multiply in GF(2^7)
    function automatic logic [6:0] gf_mul(input logic [6:0] a, input logic [6:0] b);
        logic [6:0] acc;
        logic [6:0] sh;
        acc = '0;
        sh  = a;
        for (int i = 0; i < 7; i++) begin
            if (b[i]) acc ^= sh;
            sh = sh[6] ? ({sh[5:0], 1'b0} ^ GF_RED) : {sh[5:0], 1'b0};
        end
        return acc;
    endfunction

    // product of (x + alpha^e) over the cyclotomic cosets of 1,3,...,11
    function automatic logic [PAR_W:0] bch_gen_poly();
        logic [CW_N-1:0]       root;
        logic [PAR_W:0][6:0]   c;
        logic [6:0]            pw;
        logic [PAR_W:0]        g;
        int                    j;
        root = '0;
        for (int s = 1; s <= 11; s += 2) begin
            j = s;
            for (int k = 0; k < 7; k++) begin
                root[j] = 1'b1;
                j = (2 * j) % CW_N;
            end
        end
        c    = '0;
        c[0] = 7'h01;
        pw   = 7'h01;
        for (int e = 0; e < CW_N; e++) begin
            if (root[e]) begin
                for (int k = PAR_W; k >= 1; k--)
                    c[k] = c[k-1] ^ gf_mul(c[k], pw);
                c[0] = gf_mul(c[0], pw);
            end
            pw = gf_mul(pw, 7'h02);
        end
        for (int k = 0; k <= PAR_W; k++) g[k] = c[k][0];
        return g;
    endfunction

    localparam logic [PAR_W:0] BCH_GEN = bch_gen_poly();

endpackage

// File: rtl/cidenc_table.sv
module cidenc_table
    import cidenc_pkg::*;
#(
    parameter int N_PKT = 4,
    parameter int AW    = 2
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [PAY_W-1:0] wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [PAY_W-1:0] rd_data
);

    logic [PAY_W-1:0] mem_q [N_PKT];

    always_ff @(posedge clk) begin
        if (wr_en && (int'(wr_addr) < N_PKT))
            mem_q[wr_addr] <= wr_data;
    end

    assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/cidenc_fec.sv
module cidenc_fec
    import cidenc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   step,
    input  phase_e phase,
    input  logic   pay_bit,
    output logic   coded_bit
);

    typedef struct packed {
        logic [CRC_W-1:0] crc;
        logic [PAR_W-1:0] par;
    } fec_t;

    fec_t q, d;
    logic crc_fb, par_fb;

    always_comb begin
        d = q;
        unique case (phase)
            PH_DATA: coded_bit = pay_bit;
            PH_CRC:  coded_bit = q.crc[CRC_W-1];
            PH_PAR:  coded_bit = q.par[PAR_W-1];
            default: coded_bit = 1'b0;
        endcase
        crc_fb = pay_bit ^ q.crc[CRC_W-1];
        par_fb = coded_bit ^ q.par[PAR_W-1];
        if (step) begin
            unique case (phase)
                PH_UW: d = '0;
                PH_DATA: begin
                    d.crc = {q.crc[CRC_W-2:0], 1'b0} ^ ({CRC_W{crc_fb}} & CRC_POLY);
                    d.par = {q.par[PAR_W-2:0], 1'b0} ^ ({PAR_W{par_fb}} & BCH_GEN[PAR_W-1:0]);
                end
                PH_CRC: begin
                    d.crc = {q.crc[CRC_W-2:0], 1'b0};
                    d.par = {q.par[PAR_W-2:0], 1'b0} ^ ({PAR_W{par_fb}} & BCH_GEN[PAR_W-1:0]);
                end
                default: d.par = {q.par[PAR_W-2:0], 1'b0};
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

endmodule

// File: rtl/cidenc_whiten.sv
module cidenc_whiten
    import cidenc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic step,
    input  logic scr_en,
    input  logic first,
    input  logic in_bit,
    output logic out_bit
);

    typedef struct packed {
        logic [SCR_W-1:0] lfsr;
        logic             prev;
    } wh_t;

    wh_t  q, d;
    logic prbs, sc_bit;

    always_comb begin
        d       = q;
        prbs    = q.lfsr[8] ^ q.lfsr[4];
        sc_bit  = scr_en ? (in_bit ^ prbs) : in_bit;
        out_bit = sc_bit ^ (first ? 1'b0 : q.prev);
        if (step) begin
            d.prev = out_bit;
            d.lfsr = scr_en ? {q.lfsr[SCR_W-2:0], prbs} : '1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '{lfsr: '1, prev: 1'b0};
        else     q <= d;
    end

endmodule

// File: rtl/cidenc_top.sv
module cidenc_top
    import cidenc_pkg::*;
#(
    parameter int                N_PKT  = 4,
    parameter int                UW_LEN = 16,
    parameter logic [UW_LEN-1:0] UW_PAT = 16'hE4B1,
    localparam int               AW     = (N_PKT > 1) ? $clog2(N_PKT) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [PAY_W-1:0] wr_data,
    input  logic             out_ready,
    output logic             out_valid,
    output logic             out_bit,
    output logic             out_sof
);

    localparam int CNT_MAX = (UW_LEN > PAY_W) ? UW_LEN : PAY_W;
    localparam int CNT_W   = $clog2(CNT_MAX);

    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
        logic [AW-1:0]    pkt;
        logic             ov;
        logic             ob;
        logic             osof;
    } seq_t;

    seq_t q, d;

    logic             step, first, uw_bit, pay_bit, coded_bit, pre_bit, wh_bit;
    logic [PAY_W-1:0] rd_data;

    cidenc_table #(.N_PKT(N_PKT), .AW(AW)) u_table (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (q.pkt),
        .rd_data (rd_data)
    );

    cidenc_fec u_fec (
        .clk       (clk),
        .rst       (rst),
        .step      (step),
        .phase     (q.ph),
        .pay_bit   (pay_bit),
        .coded_bit (coded_bit)
    );

    cidenc_whiten u_whiten (
        .clk     (clk),
        .rst     (rst),
        .step    (step),
        .scr_en  (q.ph != PH_UW),
        .first   (first),
        .in_bit  (pre_bit),
        .out_bit (wh_bit)
    );

    always_comb begin
        d       = q;
        step    = !q.ov || out_ready;
        first   = (q.ph == PH_UW) && (q.cnt == '0);
        uw_bit  = (int'(q.cnt) < UW_LEN) ? UW_PAT[UW_LEN-1-int'(q.cnt)] : 1'b0;
        pay_bit = (int'(q.cnt) < PAY_W)  ? rd_data[PAY_W-1-int'(q.cnt)] : 1'b0;
        pre_bit = (q.ph == PH_UW) ? uw_bit : coded_bit;
        if (step) begin
            d.ov   = 1'b1;
            d.ob   = wh_bit;
            d.osof = first;
            d.cnt  = q.cnt + CNT_W'(1);
            unique case (q.ph)
                PH_UW: if (q.cnt == CNT_W'(UW_LEN-1)) begin
                    d.ph  = PH_DATA;
                    d.cnt = '0;
                    d.pkt = '0;
                end
                PH_DATA: if (q.cnt == CNT_W'(PAY_W-1)) begin
                    d.ph  = PH_CRC;
                    d.cnt = '0;
                end
                PH_CRC: if (q.cnt == CNT_W'(CRC_W-1)) begin
                    d.ph  = PH_PAR;
                    d.cnt = '0;
                end
                default: if (q.cnt == CNT_W'(PAR_W-1)) begin
                    d.cnt = '0;
                    if (q.pkt == AW'(N_PKT-1)) begin
                        d.ph = PH_UW;
                    end else begin
                        d.ph  = PH_DATA;
                        d.pkt = q.pkt + AW'(1);
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '{ph: PH_UW, cnt: '0, pkt: '0, ov: 1'b0, ob: 1'b0, osof: 1'b0};
        else     q <= d;
    end

    assign out_valid = q.ov;
    assign out_bit   = q.ob;
    assign out_sof   = q.osof;

endmodule

// File: rtl/cidenc_top_chk.sv
module cidenc_top_chk #(
    parameter int                N_PKT  = 4,
    parameter int                UW_LEN = 16,
    parameter logic [UW_LEN-1:0] UW_PAT = 16'hE4B1
) (
    input logic clk,
    input logic rst,
    input logic out_ready,
    input logic out_valid,
    input logic out_bit,
    input logic out_sof
);

    localparam int FL = UW_LEN + 127 * N_PKT;
    localparam int CW = $clog2(FL);

    logic [CW-1:0] pos_q;
    logic          prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q  <= '0;
            prev_q <= 1'b0;
        end else if (out_valid && out_ready) begin
            pos_q  <= (pos_q == CW'(FL-1)) ? '0 : pos_q + CW'(1);
            prev_q <= out_bit;
        end
    end

    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (!out_valid && !out_sof));

    a_r2_sof_at_start: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_sof) |-> (pos_q == '0));

    a_r2_start_has_sof: assert property (@(posedge clk) disable iff (rst)
        (out_valid && pos_q == '0) |-> out_sof);

    a_r3_uw_pattern: assert property (@(posedge clk) disable iff (rst)
        (out_valid && int'(pos_q) < UW_LEN) |->
        ((out_bit ^ ((pos_q == '0) ? 1'b0 : prev_q)) == UW_PAT[UW_LEN-1-int'(pos_q)]));

    a_r9_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_bit) && $stable(out_sof)));

endmodule

bind cidenc_top cidenc_top_chk #(
    .N_PKT  (N_PKT),
    .UW_LEN (UW_LEN),
    .UW_PAT (UW_PAT)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_bit   (out_bit),
    .out_sof   (out_sof)
);

// File: tb/cidenc_top_tb.sv
module cidenc_top_tb;

    localparam int          NP   = 4;
    localparam int          UWL  = 16;
    localparam logic [15:0] UWP  = 16'hE4B1;
    localparam int          AW   = 2;
    localparam int          PW   = 77;
    localparam int          FL   = UWL + 127 * NP;
    localparam int          NF   = 3;
    localparam int          NB   = NF * FL;

    // stimulus vectors: table contents, replacement word, ready mask
    localparam logic [PW-1:0] PAY [NP] = '{
        77'h0,
        {PW{1'b1}},
        77'h1_2345_6789_ABCD_EF01_234,
        77'h0_F0E1_D2C3_B4A5_9687_785
    };
    localparam logic [PW-1:0] NEW_WORD = 77'h1_5555_AAAA_3333_CCCC_0F0;
    localparam logic [15:0]   RDY_PAT  = 16'b1101_1110_0111_1011;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [PW-1:0] wr_data = '0;
    logic          out_ready = 1'b0;
    logic          out_valid, out_bit, out_sof;

    cidenc_top #(.N_PKT(NP), .UW_LEN(UWL), .UW_PAT(UWP)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_bit   (out_bit),
        .out_sof   (out_sof)
    );

    always #5 clk = ~clk;

    int errs   = 0;
    int checks = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [6:0] gmul(input logic [6:0] a, input logic [6:0] b);
        logic [12:0] prod;
        prod = '0;
        for (int i = 0; i < 7; i++) if (b[i]) prod ^= (13'(a) << i);
        for (int k = 12; k >= 7; k--)
            if (prod[k]) prod ^= (13'h089 << (k - 7));
        return prod[6:0];
    endfunction

    function automatic logic [7:0] crc_ref(input logic [PW-1:0] w);
        logic [7:0] r;
        logic       f;
        r = '0;
        for (int i = PW - 1; i >= 0; i--) begin
            f = w[i] ^ r[7];
            r = {r[6:0], 1'b0};
            if (f) r ^= 8'h07;
        end
        return r;
    endfunction

    function automatic logic [6:0] synd(input logic [126:0] cv, input int j);
        logic [6:0] beta, s;
        beta = 7'h01;
        for (int i = 0; i < j; i++) beta = gmul(beta, 7'h02);
        s = '0;
        for (int k = 126; k >= 0; k--) s = gmul(s, beta) ^ {6'b0, cv[k]};
        return s;
    endfunction

    bit raw  [NB];
    bit sofs [NB];
    bit u    [FL];
    bit c    [FL];

    initial begin
        int  nrec, nsof, cyc, mism, base;
        bit  stall_pend, sb, ss, wd;
        logic [8:0]     s;
        logic           p;
        logic [UWL-1:0] uwg;
        logic [126:0]   cv;
        logic [PW-1:0]  expw;
        logic [41:0]    sy;

        repeat (3) @(negedge clk);
        chk(!out_valid && !out_sof, "R1", "idle in reset", {out_valid, out_sof}, 0);
        for (int i = 0; i < NP; i++) begin
            wr_en   = 1'b1;
            wr_addr = AW'(i);
            wr_data = PAY[i];
            @(negedge clk);
        end
        wr_en = 1'b0;
        chk(!out_valid && !out_sof, "R1", "idle after writes in reset", {out_valid, out_sof}, 0);
        rst = 1'b0;

        nrec = 0; nsof = 0; cyc = 0; stall_pend = 0; sb = 0; ss = 0;
        while (nrec < NB && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            wr_en = 1'b0;
            if (stall_pend)
                chk(out_valid && out_bit == sb && out_sof == ss, "R9", "hold while stalled",
                    {out_valid, out_bit, out_sof}, {1'b1, sb, ss});
            out_ready = RDY_PAT[cyc % 16];
            if (out_valid && out_ready) begin
                raw[nrec]  = out_bit;
                sofs[nrec] = out_sof;
                if (out_sof) begin
                    nsof++;
                    if (nsof == 3) begin   // R10: rewrite entry 1 during the unique word
                        wr_en   = 1'b1;
                        wr_addr = AW'(1);
                        wr_data = NEW_WORD;
                    end
                end
                nrec++;
                stall_pend = 0;
            end else if (out_valid) begin
                stall_pend = 1;
                sb = out_bit;
                ss = out_sof;
            end else begin
                stall_pend = 0;
            end
        end
        wd = (nrec < NB);
        if (wd) chk(0, "WD", "watchdog expired, bits received", nrec, NB);

        if (!wd) begin
            for (int f = 0; f < NF; f++) begin
                base = f * FL;
                mism = 0;
                for (int i = 0; i < FL; i++) if (sofs[base+i] != (i == 0)) mism++;
                chk(mism == 0, "R2", "start flag placement", mism, 0);
                chk(raw[base] == UWP[UWL-1], "R8", "first bit uses cleared history",
                    raw[base], UWP[UWL-1]);
                for (int i = 0; i < FL; i++)
                    u[i] = raw[base+i] ^ ((i == 0) ? 1'b0 : raw[base+i-1]);
                for (int i = 0; i < UWL; i++) uwg[UWL-1-i] = u[i];
                chk(uwg == UWP, "R3", "unique word", uwg, UWP);
                s = 9'h1FF;
                mism = 0;
                for (int i = UWL; i < FL; i++) begin
                    p = s[8] ^ s[4];
                    c[i] = u[i] ^ p;
                    s = {s[7:0], p};
                    if (f == 0 && i < UWL + 127 && u[i] != p) mism++;
                end
                if (f == 0)
                    chk(mism == 0, "R7", "all-zero codeword gives bare PRBS", mism, 0);
                for (int pk = 0; pk < NP; pk++) begin
                    for (int i = 0; i < 127; i++) cv[126-i] = c[UWL + pk*127 + i];
                    expw = (f == 2 && pk == 1) ? NEW_WORD : PAY[pk];
                    chk(cv[126:50] == expw, (f == 2 && pk == 1) ? "R10" : "R4",
                        "payload bits", cv[126:50], expw);
                    chk(cv[49:42] == crc_ref(expw), "R5", "crc bits", cv[49:42], crc_ref(expw));
                    for (int r = 0; r < 6; r++) sy[r*7 +: 7] = synd(cv, 2*r + 1);
                    chk(sy == '0, "R6", "syndromes at odd powers 1..11", sy, 0);
                end
            end
            mism = 0;
            for (int i = 0; i < FL; i++) if (raw[i] != raw[FL+i]) mism++;
            chk(mism == 0, "R7", "scrambler and history restart per frame", mism, 0);
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule